// File: doc/BRIEF.md
# Two-Tap Pre-Emphasis Edge Pulse Generator

This block watches a serial NRZ bit stream and produces the switch controls for a two-tap pre-emphasis line driver. Its clock runs at the bit rate, so one new data bit arrives on every rising clock edge. The block keeps the bit sampled on the previous edge. It compares each incoming bit with that stored bit to find a data transition and to tell its direction.

Each transition starts one pulse on each tap. The first tap gives a short boost. The second tap gives a longer pulse that holds the driver level up after the boost ends. The two taps differ only in pulse width, and each width is a whole number of bit periods. For each tap and each direction there is a true control and an opposite-polarity control, so each tap has four controls. Only the pair that matches the transition direction pulses. While the data holds its value, every true control stays low.

Top module: `preemph_edge_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the stored previous bit becomes 0. After that edge every true control (`t1_rise`, `t1_fall`, `t2_rise`, `t2_fall`) is low and every complement control is high.
- R2: When `din` is 1 at an edge where the stored bit is 0 (a rising transition), `t1_rise` and `t2_rise` go high after that edge, and `t1_fall` and `t2_fall` stay low.
- R3: When `din` is 0 at an edge where the stored bit is 1 (a falling transition), `t1_fall` and `t2_fall` go high after that edge, and `t1_rise` and `t2_rise` stay low.
- R4: Each complement control (`t1_rise_n`, `t1_fall_n`, `t2_rise_n`, `t2_fall_n`) is always the inverse of its true control.
- R5: Once the tap 2 pulse has run out, no true control goes high while the data holds its value.
- R6: A tap 1 pulse stays high for exactly `TAP1_W` clock cycles after the edge that detected the transition (default 1).
- R7: A tap 2 pulse stays high for exactly `TAP2_W` clock cycles (default 2). `TAP2_W` must be greater than `TAP1_W`, so tap 2 is still high in the cycle after tap 1 ends, and tap 2 is high whenever tap 1 is high.
- R8: A transition that arrives while a pulse is still active ends that pulse. Both taps then restart at full width with the direction of the new transition.
- R9: Because reset sets the stored bit to 0, a 1 on the first edge after reset counts as a rising transition, and a 0 on that edge causes no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial NRZ data, one bit per clock |
| t1_rise | output | 1 | Tap 1 pulse for a rising transition |
| t1_rise_n | output | 1 | Inverse of `t1_rise` |
| t1_fall | output | 1 | Tap 1 pulse for a falling transition |
| t1_fall_n | output | 1 | Inverse of `t1_fall` |
| t2_rise | output | 1 | Tap 2 pulse for a rising transition |
| t2_rise_n | output | 1 | Inverse of `t2_rise` |
| t2_fall | output | 1 | Tap 2 pulse for a falling transition |
| t2_fall_n | output | 1 | Inverse of `t2_fall` |

## Verification
A wrong stored bit shows up one cycle later. A pulse then appears on a held bit, or a real transition produces no pulse or a pulse in the wrong direction, so every bit after a transition is compared in the cycle that follows it. A width counter that loads the wrong value, or fails to restart, shows as a pulse that is one or more cycles too long or too short. The bench catches this by checking isolated transitions, long runs of held data and back-to-back transitions. Each tap also keeps its own direction, so a direction that goes wrong on only one tap shows as a rise/fall mismatch between the two taps on the very next cycle.

// File: rtl/preemph_edge_detect.sv
module preemph_edge_detect #(
  parameter int TAP1_W = 1,
  parameter int TAP2_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic t1_rise,
  output logic t1_rise_n,
  output logic t1_fall,
  output logic t1_fall_n,
  output logic t2_rise,
  output logic t2_rise_n,
  output logic t2_fall,
  output logic t2_fall_n
);

  localparam int CW = $clog2(TAP2_W + 1);

  logic       d_q;
  logic       edge_seen;
  logic [1:0] rise;
  logic [1:0] fall;

  assign edge_seen = din ^ d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= din;
  end

  for (genvar g = 0; g < 2; g++) begin : g_tap
    localparam int TW = (g == 0) ? TAP1_W : TAP2_W;
    logic [CW-1:0] cnt;
    logic          dir;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        dir <= 1'b0;
      end else if (edge_seen) begin
        cnt <= CW'(TW);
        dir <= din;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end

    assign rise[g] = (cnt != '0) &  dir;
    assign fall[g] = (cnt != '0) & ~dir;
  end

  assign t1_rise   =  rise[0];
  assign t1_rise_n = ~rise[0];
  assign t1_fall   =  fall[0];
  assign t1_fall_n = ~fall[0];
  assign t2_rise   =  rise[1];
  assign t2_rise_n = ~rise[1];
  assign t2_fall   =  fall[1];
  assign t2_fall_n = ~fall[1];

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (rise == 2'b00 && fall == 2'b00));

  p_rise_start_r2: assert property (@(posedge clk) disable iff (rst)
    (din && !d_q) |=> (rise == 2'b11 && fall == 2'b00));

  p_fall_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!din && d_q) |=> (fall == 2'b11 && rise == 2'b00));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!edge_seen && !rise[1] && !fall[1]) |=> (rise == 2'b00 && fall == 2'b00));

  p_tap2_covers_r7: assert property (@(posedge clk) disable iff (rst)
    (rise[0] || fall[0]) |-> (rise[1] == rise[0] && fall[1] == fall[0]));

endmodule

// File: tb/tb_preemph_edge_detect.sv
module tb_preemph_edge_detect;
  localparam int TAP1_W = 1;
  localparam int TAP2_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic t1_rise, t1_rise_n, t1_fall, t1_fall_n;
  logic t2_rise, t2_rise_n, t2_fall, t2_fall_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_r1 = 0;
  int m_r2 = 0;
  logic m_dir = 1'b0;
  logic m_prev = 1'b0;

  always #4 clk = ~clk;

  preemph_edge_detect #(.TAP1_W(TAP1_W), .TAP2_W(TAP2_W)) dut (
    .clk(clk), .rst(rst), .din(din),
    .t1_rise(t1_rise), .t1_rise_n(t1_rise_n),
    .t1_fall(t1_fall), .t1_fall_n(t1_fall_n),
    .t2_rise(t2_rise), .t2_rise_n(t2_rise_n),
    .t2_fall(t2_fall), .t2_fall_n(t2_fall_n)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare(input string req1, input string req2);
    logic [1:0] e1, e2;
    e1 = (m_r1 > 0) ? (m_dir ? 2'b10 : 2'b01) : 2'b00;
    e2 = (m_r2 > 0) ? (m_dir ? 2'b10 : 2'b01) : 2'b00;
    chk(req1, {2'b00, t1_rise, t1_fall}, {2'b00, e1});
    chk(req2, {2'b00, t2_rise, t2_fall}, {2'b00, e2});
    chk("R4", {t1_rise_n, t1_fall_n, t2_rise_n, t2_fall_n},
              ~{t1_rise, t1_fall, t2_rise, t2_fall});
  endtask

  task automatic step(input logic b, input string req1, input string req2);
    din = b;
    @(posedge clk);
    if (b != m_prev) begin
      m_r1 = TAP1_W; m_r2 = TAP2_W; m_dir = b;
    end else begin
      if (m_r1 > 0) m_r1--;
      if (m_r2 > 0) m_r2--;
    end
    m_prev = b;
    @(negedge clk);
    compare(req1, req2);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    @(posedge clk);
    @(posedge clk);
    m_r1 = 0; m_r2 = 0; m_dir = 1'b0; m_prev = 1'b0;
    @(negedge clk);
    chk("R1", {t1_rise, t1_fall, t2_rise, t2_fall}, 4'b0000);
    chk("R1", {t1_rise_n, t1_fall_n, t2_rise_n, t2_fall_n}, 4'b1111);
    rst = 1'b0;
  endtask

  task automatic test_first_bit_r9();
    do_reset();
    step(1'b0, "R9", "R9");
    do_reset();
    step(1'b1, "R9", "R9");
    chk("R9", {t1_rise, t2_rise}, 2'b11);
  endtask

  task automatic test_rise_r2();
    do_reset();
    step(1'b0, "R5", "R5");
    step(1'b1, "R2", "R2");
    step(1'b1, "R6", "R7");
    chk("R7", {t1_rise, t2_rise}, 2'b01);
    step(1'b1, "R6", "R7");
    chk("R7", {t2_rise, t2_fall}, 2'b00);
  endtask

  task automatic test_fall_r3();
    do_reset();
    step(1'b1, "R2", "R2");
    for (int i = 0; i < 4; i++) step(1'b1, "R5", "R5");
    step(1'b0, "R3", "R3");
    chk("R3", {t1_fall, t2_fall, t1_rise, t2_rise}, 4'b1100);
    step(1'b0, "R6", "R7");
    step(1'b0, "R5", "R5");
  endtask

  task automatic test_hold_r5();
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b0, "R5", "R5");
    step(1'b1, "R2", "R2");
    for (int i = 0; i < 8; i++) step(1'b1, "R5", "R5");
  endtask

  task automatic test_restart_r8();
    do_reset();
    step(1'b1, "R2", "R2");
    step(1'b0, "R8", "R8");
    chk("R8", {t2_fall, t2_rise}, 2'b10);
    step(1'b0, "R8", "R8");
    chk("R8", {t2_fall, t1_fall}, 2'b10);
    step(1'b0, "R5", "R5");
    for (int i = 0; i < 6; i++) step(i[0] ? 1'b0 : 1'b1, "R8", "R8");
    step(1'b0, "R6", "R7");
    step(1'b0, "R5", "R5");
  endtask

  task automatic test_mixed();
    logic [15:0] pat = 16'b1100_1011_1000_1101;
    do_reset();
    for (int i = 0; i < 16; i++) step(pat[i], "R6", "R7");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    test_first_bit_r9();
    test_rise_r2();
    test_fall_r3();
    test_hold_r5();
    test_restart_r8();
    test_mixed();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule